// File: doc/BRIEF.md
# Pipeline Interlock and Bubble Controller

This block is the stall controller for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that has no operand forwarding. Every cycle it looks at the source registers of the instruction in decode and at the destination registers and write flags of the three older instructions further down the pipe. If decode needs a value that one of them has not yet written back, it freezes the program counter and the fetch/decode register and sends a bubble into the decode/execute register. A consumer therefore leaves decode only once its producer has left write-back. A dependent instruction that directly follows a load gets three bubbles.

Conditional branches compare two registers and resolve in execute. While a branch is in decode and while it is in execute, the controller discards what fetch produced, so no instruction from the wrong path enters decode. Fetch resumes from the resolved address once the branch has moved on to memory. A saturating counter records how many bubbles the controller has inserted.

Top module: `pipe_interlock`

## Requirements
- R1: When decode uses a source register that equals the execute-stage destination, and that destination has its write flag set and is non-zero, `front_hold` and `idex_bubble` are 1 in the same cycle.
- R2: The same match against the memory-stage destination also raises `front_hold` and `idex_bubble`.
- R3: The same match against the write-back-stage destination also raises `front_hold`. A consumer placed three instructions after its producer therefore gets exactly one bubble.
- R4: Register number 0 never causes a hold. A writer whose write flag is 0 never causes a hold. A source whose use flag is 0 never causes a hold.
- R5: `idex_bubble` equals `front_hold` in every cycle.
- R6: A branch in execute raises `fetch_squash` unless `front_hold` is 1.
- R7: A branch in decode raises `fetch_squash` when there is no hold. When a branch in decode waits on a register, it is held and `fetch_squash` stays 0.
- R8: `front_hold` and `fetch_squash` are never 1 in the same cycle; hold takes priority.
- R9: `bubble_count` rises by one on each clock edge at which `idex_bubble` is 1. It saturates at its all-ones value.
- R10: While `rst_n` is 0 at a clock edge, `bubble_count` becomes 0.
- R11: A consumer that directly follows a load of its source register gets exactly three hold cycles. An instruction that directly follows a branch sees exactly two squashed fetch slots and no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rs_used | input | 1 | The decode instruction reads `id_rs` |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_rt_used | input | 1 | The decode instruction reads `id_rt` |
| id_is_branch | input | 1 | The decode instruction is a conditional branch |
| ex_rd | input | REG_W | Destination register in execute |
| ex_wr | input | 1 | Execute instruction writes the register file |
| ex_is_branch | input | 1 | The execute instruction is a conditional branch |
| mem_rd | input | REG_W | Destination register in memory |
| mem_wr | input | 1 | Memory-stage instruction writes the register file |
| wb_rd | input | REG_W | Destination register in write-back |
| wb_wr | input | 1 | Write-back instruction writes the register file |
| front_hold | output | 1 | Keep the PC and the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a NOP with all write flags cleared into decode/execute |
| fetch_squash | output | 1 | Replace the fetched instruction with a NOP and do not step the PC |
| bubble_count | output | CNT_W | Saturating count of inserted bubbles |

## Verification
`front_hold`, `idex_bubble` and `fetch_squash` are combinational, so they are due in the same cycle as the stage inputs. The bench drives those inputs just after a falling edge and samples the three outputs 1 ns later. `bubble_count` is due one rising edge after the bubble it records, so the bench reads it 1 ns after that edge and compares it with a saturating model it updates at the same point. The load-use and branch sequences close the loop through a small pipeline model in the bench, which advances its stages once per cycle from the sampled controls and counts hold and squash cycles.

// File: rtl/ilk_pkg.sv
// Shared definitions for the interlock controller.
// Assumes three in-flight writers (execute, memory, write-back) sit behind decode.
package ilk_pkg;
    localparam int unsigned NUM_WRITERS = 3;

    typedef enum logic [1:0] {
        WR_EX  = 2'd0,
        WR_MEM = 2'd1,
        WR_WB  = 2'd2
    } writer_e;
endpackage

// File: rtl/ilk_raw_detect.sv
// Read-after-write detector: flags when a used decode source equals the
// destination of a pending writer. Assumes register 0 is hard-wired to zero.
module ilk_raw_detect #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NWR   = ilk_pkg::NUM_WRITERS
) (
    input  logic [REG_W-1:0]          src_a,
    input  logic                      src_a_used,
    input  logic [REG_W-1:0]          src_b,
    input  logic                      src_b_used,
    input  logic [NWR-1:0][REG_W-1:0] wr_rd,
    input  logic [NWR-1:0]            wr_en,
    output logic                      hazard
);
    logic [NWR-1:0] hit;

    // One comparator pair for each pending writer.
    for (genvar i = 0; i < NWR; i++) begin : g_cmp
        logic live;
        assign live   = wr_en[i] && (wr_rd[i] != '0);
        assign hit[i] = live && ((src_a_used && src_a == wr_rd[i]) ||
                                 (src_b_used && src_b == wr_rd[i]));
    end

    // Any writer hit stalls decode.
    always_comb hazard = |hit;
endmodule

// File: rtl/ilk_branch_guard.sv
// Fetch squash for unresolved branches. Assumes a branch resolves in execute;
// a hold from decode takes priority, so a held fetch/decode register is never cleared.
module ilk_branch_guard (
    input  logic br_in_id,
    input  logic br_in_ex,
    input  logic hold,
    output logic squash
);
    // Discard fetch while a branch sits in decode or execute.
    always_comb squash = !hold && (br_in_id || br_in_ex);
endmodule

// File: rtl/ilk_bubble_ctr.sv
// Saturating bubble counter. Assumes one bubble per cycle at most.
module ilk_bubble_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count bubbles, stopping at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/pipe_interlock.sv
// Stall controller for a five-stage in-order pipeline without forwarding.
// Holds decode until every producer of its sources has left write-back,
// squashes fetch behind branches and counts inserted bubbles.
// Assumes the datapath loads a NOP with cleared write flags on idex_bubble.
module pipe_interlock #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs,
    input  logic             id_rs_used,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_rt_used,
    input  logic             id_is_branch,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wr,
    input  logic             ex_is_branch,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wr,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wr,
    output logic             front_hold,
    output logic             idex_bubble,
    output logic             fetch_squash,
    output logic [CNT_W-1:0] bubble_count
);
    import ilk_pkg::*;

    logic [NUM_WRITERS-1:0][REG_W-1:0] pend_rd;
    logic [NUM_WRITERS-1:0]            pend_wr;
    logic                              raw_hit;

    // Gather the pending writers in stage order.
    always_comb begin
        pend_rd[WR_EX]  = ex_rd;
        pend_rd[WR_MEM] = mem_rd;
        pend_rd[WR_WB]  = wb_rd;
        pend_wr[WR_EX]  = ex_wr;
        pend_wr[WR_MEM] = mem_wr;
        pend_wr[WR_WB]  = wb_wr;
    end

    ilk_raw_detect #(.REG_W(REG_W), .NWR(NUM_WRITERS)) u_raw (
        .src_a      (id_rs),
        .src_a_used (id_rs_used),
        .src_b      (id_rt),
        .src_b_used (id_rt_used),
        .wr_rd      (pend_rd),
        .wr_en      (pend_wr),
        .hazard     (raw_hit)
    );

    // A data hazard freezes the front end and bubbles decode/execute.
    always_comb begin
        front_hold  = raw_hit;
        idex_bubble = raw_hit;
    end

    ilk_branch_guard u_br (
        .br_in_id (id_is_branch),
        .br_in_ex (ex_is_branch),
        .hold     (raw_hit),
        .squash   (fetch_squash)
    );

    ilk_bubble_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (raw_hit),
        .count (bubble_count)
    );
endmodule

// File: rtl/pipe_interlock_chk.sv
// Checker for pipe_interlock: port-level properties, bound to every instance.
module pipe_interlock_chk #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] id_rs,
    input logic             id_rs_used,
    input logic [REG_W-1:0] id_rt,
    input logic             id_rt_used,
    input logic             id_is_branch,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_wr,
    input logic             ex_is_branch,
    input logic [REG_W-1:0] mem_rd,
    input logic             mem_wr,
    input logic [REG_W-1:0] wb_rd,
    input logic             wb_wr,
    input logic             front_hold,
    input logic             idex_bubble,
    input logic             fetch_squash,
    input logic [CNT_W-1:0] bubble_count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R1
    ex_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wr && ex_rd != '0 && id_rs_used && id_rs == ex_rd) |-> front_hold);

    // R2
    mem_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_rd != '0 && id_rt_used && id_rt == mem_rd) |-> front_hold);

    // R4
    no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ex_wr || ex_rd == '0) && (!mem_wr || mem_rd == '0) &&
         (!wb_wr || wb_rd == '0)) |-> !front_hold);

    // R4
    unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_rs_used && !id_rt_used) |-> !front_hold);

    // R5
    bubble_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble == front_hold);

    // R6
    br_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_branch && !front_hold) |-> fetch_squash);

    // R7
    br_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && !front_hold) |-> fetch_squash);

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(front_hold && fetch_squash));

    // R9
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_bubble && bubble_count != TOP) |=> bubble_count == $past(bubble_count) + 1'b1);

    // R9
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idex_bubble || bubble_count == TOP) |=> $stable(bubble_count));

    // R10
    cnt_rst_chk: assert property (@(posedge clk) !rst_n |=> bubble_count == '0);
endmodule

bind pipe_interlock pipe_interlock_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pipe_interlock_tb.sv
module pipe_interlock_tb;
    localparam int RW = 5;
    localparam int CW = 5;

    typedef struct packed {
        logic [RW-1:0] rs; logic rsu;
        logic [RW-1:0] rt; logic rtu;
        logic [RW-1:0] rd; logic wr;
        logic br;
    } ins_t;

    logic clk = 0;
    logic rst_n = 0;
    logic [RW-1:0] id_rs = 0, id_rt = 0, ex_rd = 0, mem_rd = 0, wb_rd = 0;
    logic id_rs_used = 0, id_rt_used = 0, id_is_branch = 0;
    logic ex_wr = 0, ex_is_branch = 0, mem_wr = 0, wb_wr = 0;
    logic front_hold, idex_bubble, fetch_squash;
    logic [CW-1:0] bubble_count;

    int total = 0, bad = 0;
    int exp_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pipe_interlock #(.REG_W(RW), .CNT_W(CW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit hit(input logic [RW-1:0] s, input bit u,
                               input logic [RW-1:0] d, input bit w);
        return u && w && d != 0 && s == d;
    endfunction

    function automatic bit exp_hold();
        return hit(id_rs, id_rs_used, ex_rd, ex_wr)  || hit(id_rt, id_rt_used, ex_rd, ex_wr) ||
               hit(id_rs, id_rs_used, mem_rd, mem_wr) || hit(id_rt, id_rt_used, mem_rd, mem_wr) ||
               hit(id_rs, id_rs_used, wb_rd, wb_wr)  || hit(id_rt, id_rt_used, wb_rd, wb_wr);
    endfunction

    task automatic check_comb(input string tag);
        bit h;
        bit s;
        h = exp_hold();
        s = !h && (id_is_branch || ex_is_branch);
        chk(front_hold == h, {tag, " R1/R2/R3/R4 hold"}, front_hold, h);
        chk(idex_bubble == h, {tag, " R5 bubble"}, idex_bubble, h);
        chk(fetch_squash == s, {tag, " R6/R7/R8 squash"}, fetch_squash, s);
    endtask

    // Closed-loop pipeline model: runs a short program, counts holds and squashes.
    task automatic run_prog(input ins_t p0, input ins_t p1, input ins_t p2, input ins_t p3,
                            output int holds, output int sqs);
        ins_t prog[8];
        ins_t id_s, ex_s, mem_s, wb_s;
        int pc;
        prog = '{default: '0};
        prog[0] = p0; prog[1] = p1; prog[2] = p2; prog[3] = p3;
        id_s = '0; ex_s = '0; mem_s = '0; wb_s = '0;
        pc = 0; holds = 0; sqs = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            id_rs = id_s.rs; id_rs_used = id_s.rsu; id_rt = id_s.rt; id_rt_used = id_s.rtu;
            id_is_branch = id_s.br;
            ex_rd = ex_s.rd; ex_wr = ex_s.wr; ex_is_branch = ex_s.br;
            mem_rd = mem_s.rd; mem_wr = mem_s.wr; wb_rd = wb_s.rd; wb_wr = wb_s.wr;
            #1;
            if (front_hold) holds++;
            if (fetch_squash) sqs++;
            wb_s = mem_s; mem_s = ex_s;
            if (front_hold) begin
                ex_s = '0;
            end else begin
                ex_s = id_s;
                if (fetch_squash) id_s = '0;
                else begin
                    id_s = (pc < 8) ? prog[pc] : '0;
                    pc++;
                end
            end
        end
    endtask

    function automatic ins_t mk(input int rs, input bit rsu, input int rt, input bit rtu,
                                input int rd, input bit wr, input bit br);
        ins_t x;
        x.rs = rs[RW-1:0]; x.rsu = rsu; x.rt = rt[RW-1:0]; x.rtu = rtu;
        x.rd = rd[RW-1:0]; x.wr = wr; x.br = br;
        return x;
    endfunction

    initial begin
        int hcnt, scnt;
        ins_t nop;
        void'($urandom(32'd4711));
        nop = '0;

        // Reset with a live hazard on the inputs: counter must stay zero.
        id_rs = 5'd3; id_rs_used = 1; ex_rd = 5'd3; ex_wr = 1;
        repeat (3) @(posedge clk);
        #1 chk(bubble_count == 0, "R10 reset count", bubble_count, 0);
        @(negedge clk); rst_n = 1;
        id_rs_used = 0; ex_wr = 0;

        // Directed: EX, MEM, WB matches, register 0 and unused sources.
        @(negedge clk);
        id_rs = 5'd4; id_rs_used = 1; id_rt = 0; id_rt_used = 0; id_is_branch = 0;
        ex_rd = 5'd4; ex_wr = 1; ex_is_branch = 0; mem_wr = 0; wb_wr = 0;
        #1 chk(front_hold == 1, "R1 ex match", front_hold, 1);
        @(negedge clk);
        ex_wr = 0; id_rt = 5'd9; id_rt_used = 1; mem_rd = 5'd9; mem_wr = 1;
        #1 chk(front_hold == 1, "R2 mem match", front_hold, 1);
        @(negedge clk);
        mem_wr = 0; wb_rd = 5'd4; wb_wr = 1;
        #1 chk(front_hold == 1, "R3 wb match", front_hold, 1);
        @(negedge clk);
        id_rs = 0; id_rt = 0; ex_rd = 0; ex_wr = 1; mem_rd = 0; mem_wr = 1; wb_rd = 0; wb_wr = 1;
        #1 chk(front_hold == 0, "R4 register zero", front_hold, 0);
        @(negedge clk);
        id_rs = 5'd6; id_rs_used = 0; id_rt = 5'd6; id_rt_used = 0; ex_rd = 5'd6;
        #1 chk(front_hold == 0, "R4 unused source", front_hold, 0);
        @(negedge clk);
        id_rs_used = 1; ex_wr = 0; mem_wr = 0; wb_wr = 0;
        #1 chk(front_hold == 0, "R4 write flag clear", front_hold, 0);
        @(negedge clk);
        ex_wr = 1; id_is_branch = 1;
        #1 chk(fetch_squash == 0 && front_hold == 1, "R7 held branch no squash", fetch_squash, 0);
        @(negedge clk);
        ex_wr = 0; ex_is_branch = 1; id_is_branch = 0;
        #1 chk(fetch_squash == 1, "R6 branch in ex squash", fetch_squash, 1);

        // Fresh reset for the counter model.
        @(negedge clk); rst_n = 0; ex_is_branch = 0; id_rs_used = 0;
        @(posedge clk); #1 chk(bubble_count == 0, "R10 reset again", bubble_count, 0);
        @(negedge clk); rst_n = 1;
        exp_cnt = 0;

        // Random phase: small register range to make matches common.
        for (int i = 0; i < 3000; i++) begin
            bit b;
            @(negedge clk);
            id_rs = RW'($urandom_range(0, 3)); id_rs_used = 1'($urandom);
            id_rt = RW'($urandom_range(0, 3)); id_rt_used = 1'($urandom);
            id_is_branch = ($urandom_range(0, 3) == 0);
            ex_rd = RW'($urandom_range(0, 3)); ex_wr = ($urandom_range(0, 2) == 0);
            ex_is_branch = ($urandom_range(0, 3) == 0);
            mem_rd = RW'($urandom_range(0, 3)); mem_wr = ($urandom_range(0, 2) == 0);
            wb_rd = RW'($urandom_range(0, 3)); wb_wr = ($urandom_range(0, 2) == 0);
            #1 check_comb("random");
            b = exp_hold();
            @(posedge clk); #1;
            if (b && exp_cnt != (1 << CW) - 1) exp_cnt++;
            chk(bubble_count == exp_cnt[CW-1:0], "R9 count", bubble_count, exp_cnt);
        end
        chk(bubble_count == (1 << CW) - 1, "R9 saturated", bubble_count, (1 << CW) - 1);

        // Load-use: three holds.
        run_prog(mk(0,0,0,0,5,1,0), mk(5,1,2,1,8,1,0), nop, nop, hcnt, scnt);
        chk(hcnt == 3, "R11 load-use holds", hcnt, 3);
        chk(scnt == 0, "R11 load-use squashes", scnt, 0);
        // Producer three ahead: one hold.
        run_prog(mk(0,0,0,0,7,1,0), mk(1,1,0,0,10,1,0), mk(2,1,0,0,11,1,0), mk(0,0,7,1,12,1,0),
                 hcnt, scnt);
        chk(hcnt == 1, "R3 distance three holds", hcnt, 1);
        // Branch: two squashed slots.
        run_prog(mk(1,1,2,1,0,0,1), mk(3,1,0,0,4,1,0), nop, nop, hcnt, scnt);
        chk(scnt == 2, "R11 branch squashes", scnt, 2);
        chk(hcnt == 0, "R11 branch holds", hcnt, 0);
        // Writes to register 0 never hold.
        run_prog(mk(0,0,0,0,0,1,0), mk(0,1,0,1,3,1,0), nop, nop, hcnt, scnt);
        chk(hcnt == 0, "R4 zero register sequence", hcnt, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule